// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Interpreter

This block stands on the device side of a byte-wide NOR flash bus. It can therefore act as a self-checking target for a flash host controller. On each rising edge of the write strobe, taken while the chip is selected, it latches one bus write. It recognises the unlock handshake that guards the program and erase commands. A write that is not part of a valid sequence is dropped.

An accepted command starts a timed internal operation. Its length is a parameterised cycle count, scaled far below real cell times. While the operation runs, the block raises `busy`, and every read returns a polling byte. In that byte, bit 7 is the complement of the bit 7 the finished location will hold. When the timer expires, the result is committed to a small register array, and reads then return the stored data. Bus strobes are sampled on the block clock, so every strobe level must be held for at least two clock cycles.

Top module: `nor_cmd_model`

## Requirements
- R1: After reset, `busy` is 0 and every location reads 0xFF.
- R2: A write is latched only on a low-to-high transition of `we_n` seen while `ce_n` is low. Strobes with `ce_n` high change nothing.
- R3: The program command is accepted only as this sequence: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then the data byte to the target address. The command addresses are compared on `addr[14:0]` only.
- R4: Programming can only clear bits. The stored byte becomes the old byte ANDed with the new data.
- R5: Sector erase is the five-write prefix 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, followed by 0x30 at any address in the target sector. It sets every byte of that sector to 0xFF and leaves the other sectors alone.
- R6: The same prefix followed by 0x10 at 0x5555 sets every byte of the array to 0xFF.
- R7: A write that breaks a sequence returns the interpreter to idle without touching memory. A correct sequence afterwards still works.
- R8: `busy` rises one clock after the edge that accepts the final write. It stays high for exactly PGM_CYC cycles for a program and ERS_CYC cycles for an erase.
- R9: While `busy` is high, a read returns {~bit7_expected, 7'b0}. The expected bit 7 is the programmed data's bit 7, or 1 for an erase.
- R10: `dout_en` is high only while both `ce_n` and `oe_n` are low. Otherwise `dout` is 0x00.
- R11: Writes issued while `busy` is high are ignored. They neither start a command nor alter memory.
- R12: The storage index is {addr[16:14], addr[2:0]}: eight sectors selected by the top three address bits, with a few bytes kept per sector. Addresses that differ only in bits 13:3 alias to the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; a write is latched on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling status, 0x00 when not driven |
| dout_en | output | 1 | High while the data bus is driven |
| busy | output | 1 | High while a program or erase is running |

## Verification
The bench aims at several corner cases, and each one has a recognisable failure:
- **Repeated program of one byte.** A design that overwrote instead of ANDing would show the new data rather than the combined value.
- **Broken sequences and strobes with the chip deselected.** A decoder that failed to reset would program memory from a stale partial sequence.
- **Busy length.** It is counted cycle by cycle, for both program and erase, so an off-by-one timer shows as a wrong count.
- **Status reads and a complete program sequence issued while an erase runs.** A design that leaked true data, or accepted commands while busy, would return a wrong status byte or a cleared target byte.
- **Sector erase and aliased addresses.** These expose wrong sector decoding or a wrong index fold.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PGM,
    SQ_ERS1,
    SQ_ERS2,
    SQ_ERS3
  } seq_e;

  typedef enum logic [1:0] {
    OP_PGM  = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2
  } op_e;

  localparam logic [14:0] ADR_KEY_A = 15'h5555;
  localparam logic [14:0] ADR_KEY_B = 15'h2AAA;

  localparam logic [7:0] DAT_KEY_A  = 8'hAA;
  localparam logic [7:0] DAT_KEY_B  = 8'h55;
  localparam logic [7:0] DAT_PGM    = 8'hA0;
  localparam logic [7:0] DAT_ERS    = 8'h80;
  localparam logic [7:0] DAT_SECT   = 8'h30;
  localparam logic [7:0] DAT_CHIP   = 8'h10;

endpackage

// File: rtl/nor_we_edge.sv
module nor_we_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic wr_evt
);

  logic we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign wr_evt = we_n && !we_q && !ce_n;

  // R2: one strobe rise gives a single event
  p_single_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              start,
  output op_e               start_op
);

  seq_e st_q, st_d;
  logic is_a, is_b;

  assign is_a = (addr[14:0] == ADR_KEY_A);
  assign is_b = (addr[14:0] == ADR_KEY_B);

  always_comb begin
    st_d     = st_q;
    start    = 1'b0;
    start_op = OP_PGM;
    if (wr_evt && !busy) begin
      st_d = SQ_IDLE;
      unique case (st_q)
        SQ_IDLE: if (is_a && din == DAT_KEY_A) st_d = SQ_KEY1;
        SQ_KEY1: if (is_b && din == DAT_KEY_B) st_d = SQ_KEY2;
        SQ_KEY2: begin
          if (is_a && din == DAT_PGM)      st_d = SQ_PGM;
          else if (is_a && din == DAT_ERS) st_d = SQ_ERS1;
        end
        SQ_PGM: begin
          start    = 1'b1;
          start_op = OP_PGM;
        end
        SQ_ERS1: if (is_a && din == DAT_KEY_A) st_d = SQ_ERS2;
        SQ_ERS2: if (is_b && din == DAT_KEY_B) st_d = SQ_ERS3;
        SQ_ERS3: begin
          if (din == DAT_SECT) begin
            start    = 1'b1;
            start_op = OP_SECT;
          end else if (is_a && din == DAT_CHIP) begin
            start    = 1'b1;
            start_op = OP_CHIP;
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  // R11: while an operation runs the interpreter stays idle
  p_idle_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> st_q == SQ_IDLE);

  // R2: commands only start from a latched write
  p_start_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> wr_evt);

endmodule

// File: rtl/nor_op_engine.sv
module nor_op_engine
  import nor_cmd_pkg::*;
#(
  parameter int PGM_CYC = 12,
  parameter int ERS_CYC = 40,
  parameter int IDX_W   = 6,
  parameter int SECT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_e               start_op,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [7:0]        start_data,
  input  logic [SECT_W-1:0] start_sect,
  output logic              busy,
  output logic              done,
  output op_e               op_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [7:0]        data_q,
  output logic [SECT_W-1:0] sect_q
);

  localparam int MAXC  = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  assign done = busy_q && (cnt_q == '0);
  assign busy = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = (start_op == OP_PGM) ? CNT_W'(PGM_CYC - 1) : CNT_W'(ERS_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PGM;
      idx_q  <= '0;
      data_q <= '0;
      sect_q <= '0;
    end else if (start) begin
      op_q   <= start_op;
      idx_q  <= start_idx;
      data_q <= start_data;
      sect_q <= start_sect;
    end
  end

  // R11: no new command while one is running
  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R8: countdown stays inside the window of the running operation
  p_cnt_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((op_q == OP_PGM) ? (cnt_q < CNT_W'(PGM_CYC)) : (cnt_q < CNT_W'(ERS_CYC))));

  // R8: busy rises only after an accepted command
  p_rise_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));

endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array
  import nor_cmd_pkg::*;
#(
  parameter int SECT_W = 3,
  parameter int OFFS_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     done,
  input  op_e                      op_q,
  input  logic [SECT_W+OFFS_W-1:0] idx_q,
  input  logic [7:0]               data_q,
  input  logic [SECT_W-1:0]        sect_q,
  input  logic [SECT_W+OFFS_W-1:0] rd_idx,
  output logic [7:0]               rd_byte
);

  localparam int IDX_W = SECT_W + OFFS_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][7:0] mem_q, mem_d;
  logic [DEPTH-1:0]      sect_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    localparam logic [SECT_W-1:0] GS = SECT_W'(g >> OFFS_W);
    assign sect_hit[g] = (GS == sect_q);
  end

  always_comb begin
    mem_d = mem_q;
    for (int i = 0; i < DEPTH; i++) begin
      unique case (op_q)
        OP_PGM:  if (IDX_W'(i) == idx_q) mem_d[i] = mem_q[i] & data_q;
        OP_SECT: if (sect_hit[i]) mem_d[i] = 8'hFF;
        OP_CHIP: mem_d[i] = 8'hFF;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mem_q <= '1;
    else if (done) mem_q <= mem_d;
  end

  assign rd_byte = mem_q[rd_idx];

  // R7: memory changes only when an operation completes
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(mem_q));

  // R4: program can only clear bits
  p_pgm_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_PGM) |=>
      mem_q[$past(idx_q)] == ($past(mem_q[idx_q]) & $past(data_q)));

  // R5: the first byte of the erased sector reads all ones
  p_sect_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_SECT) |=> mem_q[{$past(sect_q), OFFS_W'(0)}] == 8'hFF);

endmodule

// File: rtl/nor_cmd_model.sv
module nor_cmd_model
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int SECT_W  = 3,
  parameter int OFFS_W  = 3,
  parameter int PGM_CYC = 12,
  parameter int ERS_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              busy
);

  localparam int IDX_W = SECT_W + OFFS_W;

  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic              wr_evt, start, done;
  op_e               start_op, op_q;
  logic [IDX_W-1:0]  bus_idx, idx_q;
  logic [SECT_W-1:0] bus_sect, sect_q;
  logic [7:0]        data_q, rd_byte;
  logic              exp7;

  assign bus_sect = addr[ADDR_W-1 -: SECT_W];
  assign bus_idx  = {bus_sect, addr[OFFS_W-1:0]};

  nor_we_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .wr_evt (wr_evt)
  );

  nor_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_evt   (wr_evt),
    .busy     (busy),
    .addr     (addr),
    .din      (din),
    .start    (start),
    .start_op (start_op)
  );

  nor_op_engine #(
    .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC), .IDX_W(IDX_W), .SECT_W(SECT_W)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start      (start),
    .start_op   (start_op),
    .start_idx  (bus_idx),
    .start_data (din),
    .start_sect (bus_sect),
    .busy       (busy),
    .done       (done),
    .op_q       (op_q),
    .idx_q      (idx_q),
    .data_q     (data_q),
    .sect_q     (sect_q)
  );

  nor_cell_array #(.SECT_W(SECT_W), .OFFS_W(OFFS_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .done    (done),
    .op_q    (op_q),
    .idx_q   (idx_q),
    .data_q  (data_q),
    .sect_q  (sect_q),
    .rd_idx  (bus_idx),
    .rd_byte (rd_byte)
  );

  assign exp7    = (op_q == OP_PGM) ? data_q[7] : 1'b1;
  assign dout_en = !ce_n && !oe_n;

  always_comb begin
    dout = 8'h00;
    if (dout_en) dout = busy ? {~exp7, 7'b0} : rd_byte;
  end

  // R9: polling byte carries no data in its low bits
  p_status_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && dout_en) |-> dout[6:0] == 7'b0);

  // R10: bus is quiet unless selected and enabled
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ce_n || oe_n) |-> (dout == 8'h00 && !dout_en));

endmodule

// File: tb/nor_cmd_model_test.sv
module nor_cmd_model_test;

  localparam int PGM_CYC = 12;
  localparam int ERS_CYC = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, we_n, oe_n;
  logic [16:0] addr;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        dout_en, busy;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  nor_cmd_model #(.ADDR_W(17), .SECT_W(3), .OFFS_W(3),
                  .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  // {address, data written, expected read-back}
  localparam logic [32:0] VEC [8] = '{
    {17'h00005, 8'h3C, 8'h3C},
    {17'h00005, 8'hF0, 8'h30},
    {17'h04001, 8'hA5, 8'hA5},
    {17'h1C007, 8'h7E, 8'h7E},
    {17'h0C003, 8'h81, 8'h81},
    {17'h1FFFF, 8'hFF, 8'h7E},
    {17'h08002, 8'h00, 8'h00},
    {17'h10004, 8'h5A, 8'h5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk);
    ce_n = !sel; we_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] v);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    #1 v = dout;
    #1 ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic pgm(input logic [16:0] a, input logic [7:0] d, input bit sel);
    wr(17'h05555, 8'hAA, sel);
    wr(17'h02AAA, 8'h55, sel);
    wr(17'h05555, 8'hA0, sel);
    wr(a, d, sel);
  endtask

  task automatic ers_pre();
    wr(17'h05555, 8'hAA, 1);
    wr(17'h02AAA, 8'h55, 1);
    wr(17'h05555, 8'h80, 1);
    wr(17'h05555, 8'hAA, 1);
    wr(17'h02AAA, 8'h55, 1);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy !== 1'b0 && guard < 1000) begin
      guard++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!ended) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 dout_en idle", dout_en, 0);
    rd(17'h00000, v); chk("R1 erased", v, 8'hFF);
    rd(17'h1C006, v); chk("R1 erased top", v, 8'hFF);

    // R10: output gating
    ce_n = 1'b0; oe_n = 1'b1; #1;
    chk("R10 oe high en", dout_en, 0); chk("R10 oe high data", dout, 0);
    ce_n = 1'b1; oe_n = 1'b0; #1;
    chk("R10 ce high en", dout_en, 0); chk("R10 ce high data", dout, 0);
    oe_n = 1'b1;

    // R3 R4 R8 R9: vector table
    foreach (VEC[k]) begin
      pgm(VEC[k][32:16], VEC[k][15:8], 1);
      rd(VEC[k][32:16], v);
      chk("R9 program status", v, {~VEC[k][15], 7'b0});
      busy_len(n);
      chk("R8 program length", n, PGM_CYC);
      @(negedge clk);
      rd(VEC[k][32:16], v);
      chk("R3 R4 read back", v, VEC[k][7:0]);
    end

    // R12: aliased address
    rd(17'h03FF5, v); chk("R12 alias", v, 8'h30);

    // R2: full sequence with chip deselected
    pgm(17'h00005, 8'h00, 0);
    @(negedge clk);
    chk("R2 deselected busy", busy, 0);
    rd(17'h00005, v); chk("R2 deselected data", v, 8'h30);

    // R7: broken sequence then a good one
    wr(17'h05555, 8'hAA, 1);
    wr(17'h02AAA, 8'h55, 1);
    wr(17'h05555, 8'h77, 1);
    wr(17'h00005, 8'h00, 1);
    @(negedge clk);
    chk("R7 broken busy", busy, 0);
    rd(17'h00005, v); chk("R7 broken data", v, 8'h30);
    pgm(17'h00005, 8'h10, 1);
    wait_idle();
    rd(17'h00005, v); chk("R7 recovery", v, 8'h10);

    // R5 R9 R11: sector erase of sector 7 with a program issued while busy
    ers_pre();
    wr(17'h1C000, 8'h30, 1);
    rd(17'h1C007, v); chk("R9 erase status", v, 8'h00);
    pgm(17'h10004, 8'h00, 1);
    chk("R11 still busy", busy, 1);
    wait_idle();
    rd(17'h1C007, v); chk("R5 sector cleared", v, 8'hFF);
    rd(17'h0C003, v); chk("R5 other sector kept", v, 8'h81);
    rd(17'h10004, v); chk("R11 ignored program", v, 8'h5A);

    // R6 R8: chip erase
    ers_pre();
    wr(17'h05555, 8'h10, 1);
    busy_len(n);
    chk("R8 erase length", n, ERS_CYC);
    @(negedge clk);
    rd(17'h0C003, v); chk("R6 chip erase a", v, 8'hFF);
    rd(17'h10004, v); chk("R6 chip erase b", v, 8'hFF);
    rd(17'h08002, v); chk("R6 chip erase c", v, 8'hFF);

    ended = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule